// File: doc/BRIEF.md
# Multi-Cycle Load/Store Processor Core

This block is a 32-bit load/store processor core that spends a different number of clock cycles on each instruction. A phase sequencer walks every instruction through fetch, decode with operand read, execute, memory access and register write-back, and leaves out the phases the instruction does not need. Only one memory port and one ALU exist. Each is shared across the cycles of an instruction, with holding registers in between: the instruction, the loaded data word, the two operands and the ALU result.

The core drives a single word-addressed memory port with byte addresses. Read data is expected in the same cycle as the address. A write takes effect at the clock edge that ends the cycle in which the write enable is high. Instructions and data share this port, so a fetch and a data access never fall in the same cycle. Typical use is a small embedded controller, where a short clock period matters more than throughput per cycle.

Top module: `mc_core`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, the core presents byte address 0 on the memory port with the write enable low, so the first fetch comes from address 0.
- R2: In the fetch cycle the core reads the word at the PC and advances the PC by 4. The next cycle therefore shows address PC+4 on the port, and a write never happens in a fetch cycle.
- R3: Cycle counts per instruction, from fetch to the next fetch: jump 2, branch-if-equal 3, register and immediate arithmetic 4, store 4, load 5. Control always goes back to fetch after the last phase.
- R4: Register-register instructions use opcode bits [31:26] = 0x00, with sources at bits [25:21] and [20:16], destination at [15:11] and function at [5:0]. The function codes are 0x20 add, 0x22 subtract (first minus second), 0x24 AND, 0x25 OR and 0x2A signed set-less-than (result 1 or 0). The result is written to the destination register.
- R5: Immediate add (opcode 0x08) writes the source at [25:21] plus the sign-extended immediate at [15:0] into the register at [20:16].
- R6: Load word (opcode 0x23) reads memory at base [25:21] plus the sign-extended immediate and writes the word into the register at [20:16].
- R7: Store word (opcode 0x2B) writes the register at [20:16] to address base plus sign-extended immediate. The write happens in exactly one cycle, the fourth of the instruction.
- R8: Branch-if-equal (opcode 0x04) compares the registers at [25:21] and [20:16]. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise execution continues at PC+4. Backward offsets are supported.
- R9: Jump (opcode 0x02) sets the PC to bits [31:28] of PC+4, followed by instruction bits [25:0], followed by two zero bits.
- R10: Register 0 always reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_addr | output | 32 | Byte address of the shared instruction/data port |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data for the word at mem_addr, same cycle |
| mem_we | output | 1 | Write enable for mem_wdata at mem_addr |

## Verification
The register file can only be seen through stores, and phase lengths can only be seen through the spacing of memory writes. The stimulus therefore brackets each instruction kind between two stores and measures the cycle gap between their write cycles. The hardest cases to reach are a taken branch with a negative offset, a register-0 write that must leave no trace, and long chains of dependent arithmetic. Directed programs cover a counted backward loop, a skipped store and a write to register 0. Programs of random arithmetic instructions from a fixed seed, ending in stores of every register, are compared against an instruction-level model in the bench.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB} phase_t;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_t;
  typedef enum logic [1:0] {PCS_ALU, PCS_RES, PCS_JMP} pc_src_t;
  typedef enum logic [1:0] {SRCB_REG, SRCB_IMM, SRCB_OFS, SRCB_FOUR} srcb_t;

  localparam logic [5:0] OP_RRR  = 6'h00;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;
  localparam logic [5:0] OP_BREQ = 6'h04;
  localparam logic [5:0] OP_JUMP = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic    ir_en;
    logic    pc_en;
    pc_src_t pc_src;
    logic    ab_en;
    logic    res_en;
    logic    srca_pc;
    srcb_t   srcb;
    alu_op_t alu_op;
    logic    dr_en;
    logic    mem_we;
    logic    addr_res;
    logic    rf_we;
    logic    dst_rd;
    logic    wb_dr;
  } ctrl_t;
endpackage

// File: rtl/mc_alu.sv
module mc_alu #(
  parameter int W = 32
) (
  input  mc_pkg::alu_op_t op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y
);
  import mc_pkg::*;
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [IW-1:0] rd_b_idx,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data
);
  logic [W-1:0] regs [NREG];

  // entry 0 is a hard zero; the others are ordinary enabled registers
  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[i] <= '0;
      else if (hit) regs[i] <= wr_data;
    end
  end

  assign rd_a = regs[rd_a_idx];
  assign rd_b = regs[rd_b_idx];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl (
  input  mc_pkg::phase_t state,
  input  logic [5:0]     opcode,
  input  logic [5:0]     funct,
  input  logic           a_eq_b,
  output mc_pkg::phase_t next_state,
  output mc_pkg::ctrl_t  ctl
);
  import mc_pkg::*;

  function automatic alu_op_t fn_to_op(logic [5:0] fn);
    case (fn)
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      FN_SLT:  return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  logic is_rrr, is_load, is_stor, is_breq, is_jump, is_addi;
  assign is_rrr  = (opcode == OP_RRR);
  assign is_load = (opcode == OP_LOAD);
  assign is_stor = (opcode == OP_STOR);
  assign is_breq = (opcode == OP_BREQ);
  assign is_jump = (opcode == OP_JUMP);
  assign is_addi = (opcode == OP_ADDI);

  always_comb begin
    ctl        = '0;
    next_state = ST_FETCH;
    unique case (state)
      ST_FETCH: begin
        ctl.ir_en   = 1'b1;
        ctl.srca_pc = 1'b1;
        ctl.srcb    = SRCB_FOUR;
        ctl.alu_op  = ALU_ADD;
        ctl.pc_en   = 1'b1;
        ctl.pc_src  = PCS_ALU;
        next_state  = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.ab_en   = 1'b1;
        ctl.srca_pc = 1'b1;
        ctl.srcb    = SRCB_OFS;
        ctl.alu_op  = ALU_ADD;
        ctl.res_en  = 1'b1;
        if (is_jump) begin
          ctl.pc_en  = 1'b1;
          ctl.pc_src = PCS_JMP;
        end else if (is_rrr || is_addi || is_load || is_stor || is_breq) begin
          next_state = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (is_breq) begin
          ctl.pc_en  = a_eq_b;
          ctl.pc_src = PCS_RES;
        end else begin
          ctl.srcb   = is_rrr ? SRCB_REG : SRCB_IMM;
          ctl.alu_op = is_rrr ? fn_to_op(funct) : ALU_ADD;
          ctl.res_en = 1'b1;
          next_state = (is_load || is_stor) ? ST_MEM : ST_WB;
        end
      end
      ST_MEM: begin
        ctl.addr_res = 1'b1;
        ctl.mem_we   = is_stor;
        ctl.dr_en    = is_load;
        next_state   = is_load ? ST_WB : ST_FETCH;
      end
      ST_WB: begin
        ctl.rf_we  = 1'b1;
        ctl.dst_rd = is_rrr;
        ctl.wb_dr  = is_load;
      end
      default: next_state = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_core.sv
module mc_core #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            mem_we
);
  import mc_pkg::*;

  localparam int RIDX_W = 5;
  localparam int NREG   = 1 << RIDX_W;
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;

  phase_t          state_q, state_d;
  ctrl_t           ctl;
  logic [XLEN-1:0] pc_q, pc_d, ir_q, dr_q, a_q, b_q, res_q;
  logic [XLEN-1:0] rf_a, rf_b, alu_a, alu_b, alu_y, imm_sx, jmp_pc;
  logic [RIDX_W-1:0] wr_idx;

  assign imm_sx = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign jmp_pc = {pc_q[XLEN-1 -: 4], ir_q[TGT_W-1:0], 2'b00};

  mc_ctrl u_ctrl (
    .state      (state_q),
    .opcode     (ir_q[31:26]),
    .funct      (ir_q[5:0]),
    .a_eq_b     (a_q == b_q),
    .next_state (state_d),
    .ctl        (ctl)
  );

  always_comb begin
    alu_a = ctl.srca_pc ? pc_q : a_q;
    unique case (ctl.srcb)
      SRCB_REG:  alu_b = b_q;
      SRCB_IMM:  alu_b = imm_sx;
      SRCB_OFS:  alu_b = imm_sx << 2;
      default:   alu_b = XLEN'(4);
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (.op(ctl.alu_op), .a(alu_a), .b(alu_b), .y(alu_y));

  assign wr_idx = ctl.dst_rd ? ir_q[15:11] : ir_q[20:16];

  mc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (ir_q[25:21]),
    .rd_b_idx (ir_q[20:16]),
    .rd_a     (rf_a),
    .rd_b     (rf_b),
    .wr_en    (ctl.rf_we),
    .wr_idx   (wr_idx),
    .wr_data  (ctl.wb_dr ? dr_q : res_q)
  );

  always_comb begin
    unique case (ctl.pc_src)
      PCS_RES: pc_d = res_q;
      PCS_JMP: pc_d = jmp_pc;
      default: pc_d = alu_y;
    endcase
  end

  // sequencer state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  // holding registers, each with its own enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      dr_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      if (ctl.pc_en)  pc_q  <= pc_d;
      if (ctl.ir_en)  ir_q  <= mem_rdata;
      if (ctl.dr_en)  dr_q  <= mem_rdata;
      if (ctl.ab_en)  a_q   <= rf_a;
      if (ctl.ab_en)  b_q   <= rf_b;
      if (ctl.res_en) res_q <= alu_y;
    end
  end

  assign mem_addr  = ctl.addr_res ? res_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = ctl.mem_we;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk (
  input logic           clk,
  input logic           rst_n,
  input mc_pkg::phase_t state,
  input logic [31:0]    pc,
  input logic [31:0]    mem_addr,
  input logic           mem_we
);
  import mc_pkg::*;

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FETCH |=> pc == $past(pc) + 32'd4);

  assert_fetch_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FETCH |-> (mem_addr == pc) && !mem_we);

  assert_write_in_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> state == ST_MEM);

  assert_fetch_to_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FETCH |=> state == ST_DECODE);

  assert_wb_to_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WB |=> state == ST_FETCH);

  assert_pc_hold_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MEM || state == ST_WB) |=> $stable(pc));
endmodule

bind mc_core mc_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state    (state_q),
  .pc       (pc_q),
  .mem_addr (mem_addr),
  .mem_we   (mem_we)
);

// File: tb/mc_core_tb_top.sv
module mc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;

  always #4 clk = ~clk;

  mc_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we)
  );

  logic [31:0] mem [256];
  assign mem_rdata = mem[mem_addr[9:2]];

  int          tests, fails, cyc, wr_n;
  logic [31:0] wr_addr [64];
  logic [31:0] wr_data [64];
  int          wr_cyc  [64];

  function automatic logic [31:0] enc_r(int fn, int rs, int rt, int rd);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'h02, tgt[25:0]};
  endfunction
  function automatic logic [31:0] ref_alu(int fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      'h22: return a - b;
      'h24: return a & b;
      'h25: return a | b;
      'h2A: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic monitor();
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && mem_we) begin
        mem[mem_addr[9:2]] = mem_wdata;
        if (wr_n < 64) begin
          wr_addr[wr_n] = mem_addr;
          wr_data[wr_n] = mem_wdata;
          wr_cyc[wr_n]  = cyc;
        end
        wr_n++;
      end
    end
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEADBEEF;
    wr_n = 0;
  endtask

  task automatic leave_reset();
    repeat (2) @(negedge clk);
    chk("R1", "addr in reset", mem_addr, 32'h0);
    chk("R1", "we in reset", {31'd0, mem_we}, 32'h0);
    rst_n = 1'b1;
    #1;
    chk("R1", "addr after release", mem_addr, 32'h0);
    @(negedge clk);
    chk("R2", "addr after first fetch", mem_addr, 32'h4);
  endtask

  task automatic gap(string req, int idx, int exp);
    chk(req, $sformatf("cycle gap before write %0d", idx),
        32'(wr_cyc[idx] - wr_cyc[idx-1]), 32'(exp));
  endtask

  task automatic directed();
    logic [31:0] ea [12];
    logic [31:0] ed [12];
    enter_reset();
    mem[0]  = enc_i('h08, 0, 1, 5);
    mem[1]  = enc_i('h08, 0, 2, -3);
    mem[2]  = enc_i('h2B, 0, 1, 'h200);
    mem[3]  = enc_j(4);
    mem[4]  = enc_i('h2B, 2, 2, 'h207);      // negative base: -3 + 0x207
    mem[5]  = enc_r('h20, 1, 2, 3);
    mem[6]  = enc_i('h2B, 0, 3, 'h208);
    mem[7]  = enc_i('h23, 1, 4, 'h1FB);      // load from 5 + 0x1FB
    mem[8]  = enc_i('h2B, 0, 4, 'h20C);
    mem[9]  = enc_i('h04, 1, 2, 5);          // not taken
    mem[10] = enc_i('h2B, 0, 1, 'h210);
    mem[11] = enc_i('h04, 1, 1, 1);          // taken, skips 12
    mem[12] = enc_i('h2B, 0, 1, 'h214);
    mem[13] = enc_i('h2B, 0, 2, 'h218);
    mem[14] = enc_r('h22, 2, 1, 5);
    mem[15] = enc_r('h24, 1, 2, 6);
    mem[16] = enc_r('h25, 1, 2, 7);
    mem[17] = enc_r('h2A, 2, 1, 8);
    mem[18] = enc_r('h20, 1, 1, 0);          // write to register 0
    mem[19] = enc_i('h2B, 0, 5, 'h220);
    mem[20] = enc_i('h2B, 0, 6, 'h224);
    mem[21] = enc_i('h2B, 0, 7, 'h228);
    mem[22] = enc_i('h2B, 0, 8, 'h22C);
    mem[23] = enc_i('h2B, 0, 0, 'h230);
    mem[24] = enc_i('h08, 0, 9, 2);
    mem[25] = enc_i('h08, 9, 9, -1);
    mem[26] = enc_i('h04, 9, 0, 1);
    mem[27] = enc_i('h04, 0, 0, -3);         // backward branch
    mem[28] = enc_i('h2B, 0, 9, 'h234);
    mem[29] = enc_j(29);
    leave_reset();
    repeat (300) @(negedge clk);

    ea = '{32'h200, 32'h204, 32'h208, 32'h20C, 32'h210, 32'h218,
           32'h220, 32'h224, 32'h228, 32'h22C, 32'h230, 32'h234};
    ed = '{32'd5, 32'hFFFFFFFD, 32'd2, 32'd5, 32'd5, 32'hFFFFFFFD,
           32'hFFFFFFF8, 32'd5, 32'hFFFFFFFD, 32'd1, 32'd0, 32'd0};
    chk("R7", "directed write count", 32'(wr_n), 32'd12);
    for (int i = 0; i < 12; i++) begin
      chk("R7", $sformatf("directed write %0d address", i), wr_addr[i], ea[i]);
    end
    chk("R5", "immediate add r1", wr_data[0], ed[0]);
    chk("R5", "negative immediate r2", wr_data[1], ed[1]);
    chk("R4", "add", wr_data[2], ed[2]);
    chk("R6", "load with base", wr_data[3], ed[3]);
    chk("R8", "not-taken path", wr_data[4], ed[4]);
    chk("R8", "taken path", wr_data[5], ed[5]);
    chk("R4", "sub", wr_data[6], ed[6]);
    chk("R4", "and", wr_data[7], ed[7]);
    chk("R4", "or", wr_data[8], ed[8]);
    chk("R4", "slt signed", wr_data[9], ed[9]);
    chk("R10", "register 0 after write", wr_data[10], ed[10]);
    chk("R8", "backward loop result", wr_data[11], ed[11]);
    chk("R8", "skipped store left memory", mem['h214 >> 2], 32'hDEADBEEF);
    gap("R9", 1, 6);    // jump 2 + store 4
    gap("R3", 2, 8);    // arithmetic 4
    gap("R6", 3, 9);    // load 5
    gap("R8", 4, 7);    // branch not taken 3
    gap("R8", 5, 7);    // branch taken 3
    gap("R3", 6, 24);   // five arithmetic ops
    gap("R7", 7, 4);    // store 4
  endtask

  task automatic random_round(int round);
    logic [31:0] m [8];
    int k, kind, rs, rt, rd, imm;
    enter_reset();
    m[0] = '0;
    k = 0;
    for (int i = 1; i < 8; i++) begin
      imm = int'($urandom() & 32'hFFFF);
      mem[k++] = enc_i('h08, 0, i, imm);
      m[i] = {{16{imm[15]}}, imm[15:0]};
    end
    for (int n = 0; n < 40; n++) begin
      kind = int'($urandom() % 6);
      rs = int'($urandom() % 8);
      rt = int'($urandom() % 8);
      rd = int'($urandom() % 8);
      if (kind == 5) begin
        imm = int'($urandom() & 32'hFFFF);
        mem[k++] = enc_i('h08, rs, rt, imm);
        if (rt != 0) m[rt] = m[rs] + {{16{imm[15]}}, imm[15:0]};
      end else begin
        int fn;
        case (kind)
          0: fn = 'h20;
          1: fn = 'h22;
          2: fn = 'h24;
          3: fn = 'h25;
          default: fn = 'h2A;
        endcase
        mem[k++] = enc_r(fn, rs, rt, rd);
        if (rd != 0) m[rd] = ref_alu(fn, m[rs], m[rt]);
      end
    end
    for (int i = 0; i < 8; i++) mem[k++] = enc_i('h2B, 0, i, 'h200 + 4 * i);
    mem[k] = enc_j(k);
    leave_reset();
    repeat (400) @(negedge clk);
    chk("R4", $sformatf("round %0d write count", round), 32'(wr_n), 32'd8);
    for (int i = 0; i < 8; i++) begin
      chk(i == 0 ? "R10" : "R4", $sformatf("round %0d register %0d", round, i),
          wr_data[i], m[i]);
      if (i > 0) gap("R7", i, 4);
    end
  endtask

  initial begin
    tests = 0;
    fails = 0;
    cyc   = 0;
    wr_n  = 0;
    rst_n = 1'b0;
    void'($urandom(32'd1357));
    fork
      monitor();
      begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not end");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
    directed();
    for (int r = 0; r < 3; r++) random_round(r);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule